// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches it through a simple register port. The port has one write strobe, a register select and two byte enables, plus a combinational read path. Hardware events also feed the block: an attention button press, device insertion and device removal. Insertion is refused while the electromechanical interlock is engaged. The block drives the two indicator fields, the power controller output and a detach pulse. It also raises a hot-plug interrupt, either as a level for INTx or as a one-cycle message request that carries a 5-bit vector for MSI/MSI-X.

Every write to slot control counts as one command, and that command completes in the same cycle. The interrupt logic keeps a single pending bit. This bit is the interrupt enable gated with the OR of the event bits, each masked by its own enable and by the supported-event mask. A message is requested only when the pending bit rises. The pending bit is tracked whatever the mode, so a change of interrupt mode keeps every outstanding event.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x00F0 (both indicators off, all enables and power-off clear), slot status reads 0x0000, and intx and msg_req are low.
- R2: The slot control layout is: event enables in bits 2:0 (button, presence change, command done), interrupt enable in bit 3, attention indicator in bits 5:4, power indicator in bits 7:6, power-off in bit 8, and interlock toggle in bit 9. Each indicator is encoded on=01, blink=10, off=11. A write updates only the bytes whose enable is set, and attn_ind, pwr_ind and pwr_off follow the stored fields.
- R3: Any write to slot control that has at least one byte enable set sets command done (status bit 2) in the same clock edge.
- R4: The status event bits 2:0 are write-1-to-clear through byte 0. An event that arrives in the same cycle as a clear takes precedence.
- R5: In INTx mode (irq_mode=0), intx equals the pending state one cycle later. It drops once a status clear leaves nothing pending.
- R6: In MSI (1) or MSI-X (2) mode, a rise of the pending state gives a one-cycle msg_req, and msg_vec holds the vector that was sampled with it. Setting an event that is already set gives no new request.
- R7: A change of irq_mode keeps all events. Switching to INTx while an event is pending raises intx.
- R8: Slot control bit 9 always reads 0. Writing 1 to it through byte 1 toggles the interlock status, status bit 9.
- R9: An accepted insertion sets presence (status bit 8) and link active (status bit 10), and raises the button and presence-change events. An insertion while the interlock is set only pulses insert_reject.
- R10: A write to slot control that leaves power-off=1 and the power indicator at off (11) while presence is set clears presence and link active, sets presence change and pulses detach.
- R11: A removal while presence is set clears presence and link active and sets presence change.
- R12: An attention button press sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 slot control, 1 slot status |
| wr_be | input | 2 | Byte enables |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 slot control, 1 slot status |
| rd_data | output | 16 | Read data |
| btn_press | input | 1 | Attention button pulse |
| dev_insert | input | 1 | Device insertion pulse |
| dev_remove | input | 1 | Device removal pulse |
| irq_mode | input | 2 | 0 INTx, 1 MSI, 2 MSI-X |
| irq_vec | input | 5 | Interrupt message number |
| attn_ind | output | 2 | Attention indicator |
| pwr_ind | output | 2 | Power indicator |
| pwr_off | output | 1 | Power controller off |
| detach | output | 1 | Detach pulse |
| insert_reject | output | 1 | Rejected insertion pulse |
| intx | output | 1 | Level interrupt |
| msg_req | output | 1 | One-cycle message request |
| msg_vec | output | 5 | Vector for msg_req |

## Verification
The bench aims at the collision cases. A status clear can meet a new event in the same cycle, and a design that lets the clear win would lose that event. Setting an event bit that is already set must not produce a second message, and a design that does would send one. A mode switch can come while an event is pending, and a design that resets the pending state on the switch would leave intx low. Random control writes land on the detach combination both with and without presence. That catches a detach that ignores presence or uses the old field values. Together with the lock-bit toggles and refused insertions, it also catches an interlock bit that reads back as 1 or that blocks nothing.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int EVT_W    = 3;
  localparam int EV_BTN   = 0;
  localparam int EV_PRES  = 1;
  localparam int EV_CMD   = 2;
  localparam int C_LOCKTG = 9;
  localparam int S_PRES   = 8;
  localparam int S_LOCK   = 9;
  localparam int S_LINK   = 10;
  localparam logic [1:0] IND_OFF = 2'b11;
  localparam logic [1:0] MODE_INTX = 2'd0;

  typedef struct packed {
    logic             pwr_off;
    logic [1:0]       pwr_ind;
    logic [1:0]       attn_ind;
    logic             hp_ie;
    logic [EVT_W-1:0] evt_en;
  } slot_ctl_t;

  localparam slot_ctl_t CTL_RST = '{pwr_off: 1'b0, pwr_ind: IND_OFF,
                                    attn_ind: IND_OFF, hp_ie: 1'b0, evt_en: '0};

  function automatic logic pend_calc(input slot_ctl_t c, input logic [EVT_W-1:0] evt,
                                     input logic [EVT_W-1:0] supp);
    return c.hp_ie & (|(evt & c.evt_en & supp));
  endfunction

  function automatic logic [15:0] merge_be(input logic [15:0] old_v, input logic [15:0] new_v,
                                           input logic [1:0] be);
    logic [15:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic             btn_press,
  input  logic             dev_insert,
  input  logic             dev_remove,
  output slot_ctl_t        ctl_q,
  output logic [EVT_W-1:0] evt_q,
  output logic             pres_q,
  output logic             link_q,
  output logic             lock_q,
  output logic             ctl_wr,
  output logic             detach_q,
  output logic             reject_q
);
  logic [15:0]      ctl_img, ctl_mrg;
  slot_ctl_t        ctl_n;
  logic             lock_flip, det_c, ins_ok, rem_ok;
  logic [EVT_W-1:0] evt_clr, evt_set;

  assign ctl_wr    = wr_en & ~wr_sel & (|wr_be);
  assign ctl_img   = {7'b0, ctl_q};
  assign ctl_mrg   = merge_be(ctl_img, wr_data, wr_be);
  assign ctl_n     = ctl_wr ? slot_ctl_t'(ctl_mrg[$bits(slot_ctl_t)-1:0]) : ctl_q;
  assign lock_flip = ctl_wr & wr_be[1] & wr_data[C_LOCKTG];
  assign det_c     = ctl_wr & pres_q & ctl_n.pwr_off & (ctl_n.pwr_ind == IND_OFF);
  assign ins_ok    = dev_insert & ~lock_q & ~det_c;
  assign rem_ok    = dev_remove & pres_q & ~dev_insert & ~det_c;
  assign evt_clr   = (wr_en & wr_sel & wr_be[0]) ? wr_data[EVT_W-1:0] : '0;

  always_comb begin
    evt_set          = '0;
    evt_set[EV_BTN]  = btn_press | ins_ok;
    evt_set[EV_PRES] = ins_ok | rem_ok | det_c;
    evt_set[EV_CMD]  = ctl_wr;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= (evt_q[i] & ~evt_clr[i]) | evt_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= CTL_RST;
      pres_q   <= 1'b0;
      link_q   <= 1'b0;
      lock_q   <= 1'b0;
      detach_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      ctl_q    <= ctl_n;
      lock_q   <= lock_q ^ lock_flip;
      detach_q <= det_c;
      reject_q <= dev_insert & lock_q;
      if (det_c || rem_ok) begin
        pres_q <= 1'b0;
        link_q <= 1'b0;
      end else if (ins_ok) begin
        pres_q <= 1'b1;
        link_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int               VEC_W     = 5,
  parameter logic [EVT_W-1:0] SUPP_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_ctl_t        ctl_q,
  input  logic [EVT_W-1:0] evt_q,
  input  logic [1:0]       irq_mode,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             pend_q,
  output logic             intx,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec
);
  logic pend_now, rise;

  assign pend_now = pend_calc(ctl_q, evt_q, SUPP_MASK);
  assign rise     = pend_now & ~pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      intx    <= 1'b0;
      msg_req <= 1'b0;
      msg_vec <= '0;
    end else begin
      pend_q  <= pend_now;
      intx    <= pend_now & (irq_mode == MODE_INTX);
      msg_req <= rise & (irq_mode != MODE_INTX);
      if (rise && irq_mode != MODE_INTX) msg_vec <= irq_vec;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int               VEC_W     = 5,
  parameter logic [EVT_W-1:0] SUPP_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic             rd_sel,
  output logic [15:0]      rd_data,
  input  logic             btn_press,
  input  logic             dev_insert,
  input  logic             dev_remove,
  input  logic [1:0]       irq_mode,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       attn_ind,
  output logic [1:0]       pwr_ind,
  output logic             pwr_off,
  output logic             detach,
  output logic             insert_reject,
  output logic             intx,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec
);
  slot_ctl_t        ctl_q;
  logic [EVT_W-1:0] evt_q;
  logic             pres_q, link_q, lock_q, ctl_wr, pend_q;
  logic [15:0]      sts_img;

  hp_slot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .btn_press(btn_press), .dev_insert(dev_insert),
    .dev_remove(dev_remove), .ctl_q(ctl_q), .evt_q(evt_q), .pres_q(pres_q),
    .link_q(link_q), .lock_q(lock_q), .ctl_wr(ctl_wr), .detach_q(detach),
    .reject_q(insert_reject)
  );

  hp_slot_notify #(.VEC_W(VEC_W), .SUPP_MASK(SUPP_MASK)) u_notify (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .evt_q(evt_q), .irq_mode(irq_mode),
    .irq_vec(irq_vec), .pend_q(pend_q), .intx(intx), .msg_req(msg_req), .msg_vec(msg_vec)
  );

  always_comb begin
    sts_img                = '0;
    sts_img[EVT_W-1:0]     = evt_q;
    sts_img[S_PRES]        = pres_q;
    sts_img[S_LOCK]        = lock_q;
    sts_img[S_LINK]        = link_q;
  end

  assign rd_data  = rd_sel ? sts_img : {7'b0, ctl_q};
  assign attn_ind = ctl_q.attn_ind;
  assign pwr_ind  = ctl_q.pwr_ind;
  assign pwr_off  = ctl_q.pwr_off;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       cmd_done,
  input logic       msg_req,
  input logic       intx,
  input logic [1:0] irq_mode,
  input logic       detach,
  input logic       pres,
  input logic       pres_chg,
  input logic       insert_reject,
  input logic       lock
);
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> cmd_done); // R3
  AST_MSG_PULSE: assert property (@(posedge clk) disable iff (!rst_n) msg_req |=> !msg_req); // R6
  AST_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n) msg_req |-> $past(irq_mode) != 2'd0); // R6
  AST_INTX_MODE: assert property (@(posedge clk) disable iff (!rst_n) intx |-> $past(irq_mode) == 2'd0); // R5
  AST_DETACH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) detach |-> (!pres && pres_chg)); // R10
  AST_REJECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n) insert_reject |-> $past(lock)); // R9
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cmd_done(evt_q[2]), .msg_req(msg_req),
  .intx(intx), .irq_mode(irq_mode), .detach(detach), .pres(pres_q), .pres_chg(evt_q[1]),
  .insert_reject(insert_reject), .lock(lock_q)
);

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/100ps
module hp_slot_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, btn_press = 0, dev_insert = 0, dev_remove = 0;
  logic [1:0] wr_be = 0, irq_mode = 0;
  logic [15:0] wr_data = 0;
  logic [4:0] irq_vec = 0;
  logic [15:0] rd_data;
  logic [1:0] attn_ind, pwr_ind;
  logic pwr_off, detach, insert_reject, intx, msg_req;
  logic [4:0] msg_vec;
  int checks = 0, fails = 0;

  // bench model state
  logic [8:0] m_ctl; logic [2:0] m_evt; logic m_pres, m_link, m_lock;
  logic m_pend, m_intx, m_msg, m_det, m_rej; logic [4:0] m_vec;

  always #2 clk = ~clk;

  hp_slot_ctrl u_dut (.*);

  function automatic logic f_pend(input logic [8:0] c, input logic [2:0] e);
    return c[3] && ((c[2:0] & e) != 3'b000);
  endfunction

  function automatic logic [15:0] f_rd(input logic s);
    return s ? {5'b0, m_link, m_lock, m_pres, 5'b0, m_evt} : {7'b0, m_ctl};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic s, output logic [15:0] d);
    rd_sel = s; #0.2; d = rd_data;
  endtask

  task automatic step(input logic we, input logic ws, input logic [1:0] be, input logic [15:0] d,
                      input logic b, input logic ins, input logic rem, input string tag);
    logic [8:0] cn; logic [15:0] mg; logic cw, lf, dc, io, ro, pn; logic [2:0] cl, st;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_be = be; wr_data = d;
    btn_press = b; dev_insert = ins; dev_remove = rem; rd_sel = $urandom_range(0, 1);
    cw = we && !ws && be != 2'b00;
    mg[7:0]  = be[0] ? d[7:0]  : {m_ctl[7:0]};
    mg[15:8] = be[1] ? d[15:8] : {7'b0, m_ctl[8]};
    cn = cw ? mg[8:0] : m_ctl;
    lf = cw && be[1] && d[9];
    dc = cw && m_pres && cn[8] && cn[7:6] == 2'b11;
    io = ins && !m_lock && !dc;
    ro = rem && m_pres && !ins && !dc;
    cl = (we && ws && be[0]) ? d[2:0] : 3'b000;
    st = {cw, io || ro || dc, b || io};
    pn = f_pend(m_ctl, m_evt);
    @(posedge clk); #0.5;
    m_msg = pn && !m_pend && irq_mode != 2'd0;
    if (m_msg) m_vec = irq_vec;
    m_intx = pn && irq_mode == 2'd0;
    m_pend = pn;
    m_rej = ins && m_lock;
    m_det = dc;
    m_lock = m_lock ^ lf;
    if (dc || ro) begin m_pres = 0; m_link = 0; end
    else if (io) begin m_pres = 1; m_link = 1; end
    m_evt = (m_evt & ~cl) | st;
    m_ctl = cn;
    chk({tag, " rd"}, rd_data, f_rd(rd_sel));
    chk({tag, " R5 intx"}, intx, m_intx);
    chk({tag, " R6 msg_req"}, msg_req, m_msg);
    if (m_msg) chk({tag, " R6 msg_vec"}, msg_vec, m_vec);
    chk({tag, " R10 detach"}, detach, m_det);
    chk({tag, " R9 insert_reject"}, insert_reject, m_rej);
    chk({tag, " R2 outputs"}, {attn_ind, pwr_ind, pwr_off}, {m_ctl[5:4], m_ctl[7:6], m_ctl[8]});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 2'b00, 16'h0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4711));
    m_ctl = 9'h0F0; m_evt = 0; m_pres = 0; m_link = 0; m_lock = 0;
    m_pend = 0; m_intx = 0; m_msg = 0; m_det = 0; m_rej = 0; m_vec = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.5;
    peek(0, r); chk("R1 ctl reset", r, 16'h00F0);
    peek(1, r); chk("R1 sts reset", r, 16'h0000);
    chk("R1 intx reset", {intx, msg_req}, 2'b00);

    // R2 byte-enable write, R3 command done
    step(1, 0, 2'b01, 16'h030B, 0, 0, 0, "R2 byte0 write");
    peek(0, r); chk("R2 ctl byte0 only", r, 16'h000B);
    peek(1, r); chk("R3 cmd done set", r[2], 1'b1);
    // R12 button, R5 intx
    step(0, 0, 2'b00, 0, 1, 0, 0, "R12 button");
    peek(1, r); chk("R12 button status", r[0], 1'b1);
    idle("R5 intx rise");
    chk("R5 intx high", intx, 1'b1);
    // R4 clear
    step(1, 1, 2'b01, 16'h0001, 0, 0, 0, "R4 clear");
    idle("R5 intx fall");
    chk("R5 intx low after clear", intx, 1'b0);
    // R4 clear colliding with event
    step(1, 1, 2'b01, 16'h0001, 1, 0, 0, "R4 collide");
    peek(1, r); chk("R4 event wins", r[0], 1'b1);
    step(1, 1, 2'b01, 16'h0001, 0, 0, 0, "R4 clear2");
    idle("R4 settle");
    // R6 MSI
    irq_mode = 2'd1; irq_vec = 5'd19;
    step(0, 0, 2'b00, 0, 1, 0, 0, "R6 msi event");
    idle("R6 msi req");
    chk("R6 msg pulse", {msg_req, msg_vec}, {1'b1, 5'd19});
    step(0, 0, 2'b00, 0, 1, 0, 0, "R6 repeat event");
    idle("R6 no repeat");
    chk("R6 no second msg", msg_req, 1'b0);
    // R7 mode change
    irq_mode = 2'd0;
    idle("R7 to intx");
    chk("R7 intx after switch", intx, 1'b1);
    // R8 lock toggle
    step(1, 0, 2'b10, 16'h0200, 0, 0, 0, "R8 lock toggle");
    peek(0, r); chk("R8 toggle reads 0", r[9], 1'b0);
    peek(1, r); chk("R8 lock status", r[9], 1'b1);
    // R9 rejected then accepted insertion
    step(0, 0, 2'b00, 0, 0, 1, 0, "R9 reject");
    chk("R9 reject pulse", insert_reject, 1'b1);
    peek(1, r); chk("R9 no presence", r[8], 1'b0);
    step(1, 0, 2'b10, 16'h0200, 0, 0, 0, "R8 unlock");
    step(1, 1, 2'b01, 16'h0007, 0, 0, 0, "R4 clear all");
    step(0, 0, 2'b00, 0, 0, 1, 0, "R9 insert");
    peek(1, r); chk("R9 insert status", r & 16'h0703, 16'h0503);
    // R10 detach
    step(1, 0, 2'b11, 16'h01CB, 0, 0, 0, "R10 detach");
    chk("R10 detach pulse", detach, 1'b1);
    peek(1, r); chk("R10 status", r & 16'h0502, 16'h0002);
    // R11 removal
    step(0, 0, 2'b00, 0, 0, 1, 0, "R11 insert");
    step(1, 1, 2'b01, 16'h0007, 0, 0, 0, "R11 clear");
    step(0, 0, 2'b00, 0, 0, 0, 1, "R11 remove");
    peek(1, r); chk("R11 removal", r & 16'h0502, 16'h0002);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic we, ws; logic [1:0] be; logic [15:0] d;
      if ($urandom_range(0, 49) == 0) irq_mode = 2'($urandom_range(0, 2));
      irq_vec = 5'($urandom_range(0, 31));
      we = $urandom_range(0, 9) < 3;
      ws = $urandom_range(0, 1);
      be = 2'($urandom_range(0, 3));
      d  = 16'($urandom());
      if (!ws && $urandom_range(0, 3) == 0) d[8:6] = 3'b111;
      step(we, ws, be, d, $urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
           $urandom_range(0, 19) == 0, "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule